// File: doc/BRIEF.md
# DC-Balance Word Inversion Encoder

This block sits in front of a serializer on a DC-coupled or long-cable link. It takes each parallel data word and decides whether to send it as it is or with every bit flipped, so that the count of ones and zeros on the line stays close to even over time. Each output word carries one extra inversion flag bit. A receiver uses that flag to undo the inversion.

The encoder keeps a signed running disparity: the number of ones minus the number of zeros sent so far. The flag bit counts toward this total as an ordinary line bit. The invert decision depends only on the sign of the running disparity and the sign of the incoming word's own disparity. Whenever the running disparity is exactly zero, the word is always inverted.

Control is a four-state machine. The states are `ST_OFF` (balancing disabled) and three states that record the sign of the running disparity: `ST_ZERO`, `ST_NEG` and `ST_POS`. Its transitions are:
- `T_DISABLE`: any state goes to `ST_OFF` when the enable is low.
- `T_ENABLE`: `ST_OFF` goes to `ST_ZERO` when the enable is high and no word is accepted.
- `T_TO_NEG`, `T_TO_ZERO`, `T_TO_POS`: when an accepted word leaves the total negative, zero or positive, the machine moves to the matching state.
- `T_HOLD`: when no word is accepted, the machine stays where it is.

Top module: `dcb_word_encoder`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `out_valid` is 0, `out_flag` is 0 and `out_rd` is 0.
- R2: While `bal_en` is 0, an accepted word appears unchanged on `out_word` one cycle later, and `out_flag` is 0.
- R3: When balancing is enabled and the running disparity is zero, the accepted word is sent inverted (`out_word` = ~`in_word`) and `out_flag` is 1. A word's disparity is 2×(number of ones) − DATA_W.
- R4: When the running disparity is negative and the word's disparity is positive, the word is sent unmodified and the flag is 0.
- R5: When the running disparity is negative and the word's disparity is zero or negative, the word is sent inverted and the flag is 1.
- R6: When the running disparity is positive and the word's disparity is zero or negative, the word is sent unmodified and the flag is 0.
- R7: When the running disparity is positive and the word's disparity is positive, the word is sent inverted and the flag is 1.
- R8: After each accepted word with balancing enabled, `out_rd` grows by the disparity of the transmitted (DATA_W+1)-bit symbol {flag, word}: 2×(ones in the symbol) − (DATA_W+1).
- R9: `out_rd` always stays within −DATA_W to DATA_W+1.
- R10: Outputs are registered with one cycle of latency. `out_valid` follows `in_valid`. `out_flag` is 0 and `out_rd` holds its value in a cycle that follows no accepted word.
- R11: A cycle with `bal_en` at 0 clears `out_rd` to 0 on the next cycle. When balancing is re-enabled, it starts from a running disparity of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bal_en | input | 1 | Balance-mode enable |
| in_valid | input | 1 | Input word strobe |
| in_word | input | DATA_W | Data word to encode |
| out_valid | output | 1 | Output word strobe |
| out_word | output | DATA_W | Encoded (possibly inverted) word |
| out_flag | output | 1 | Inversion flag sent with the word |
| out_rd | output | clog2(DATA_W+2)+1 | Signed running disparity after the last word |

## Verification
The hardest situations to reach are the two ends of the disparity range. Reaching them takes a planned chain of words. For the low end, the total is first driven to +1, and an all-zeros word is then sent unmodified to land on −DATA_W. For the high end, an all-zeros word is sent while the total is exactly zero, which forces inversion and lands on DATA_W+1. A perfectly balanced word arriving at a positive or negative total is the other edge case, since its zero disparity must take the negative-word branch. A directed sequence builds each of these in order. A long random run with gaps in the strobe and drops of the enable then follows, and a behavioural model in the bench checks it cycle by cycle.

// File: rtl/dcb_pkg.sv
package dcb_pkg;

    // Encoder control states: balancing off, or the sign of the running total
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_ZERO = 2'd1,
        ST_NEG  = 2'd2,
        ST_POS  = 2'd3
    } dcb_state_e;

endpackage

// File: rtl/dcb_word_disparity.sv
module dcb_word_disparity #(
    parameter int DATA_W = 24,
    parameter int RD_W   = 6
) (
    input  logic [DATA_W-1:0]      word_i,
    output logic signed [RD_W-1:0] disp_o,
    output logic                   disp_pos_o
);
    localparam int CNT_W = $clog2(DATA_W + 1);

    logic [CNT_W-1:0] ones;

    always_comb begin
        ones = '0;
        for (int i = 0; i < DATA_W; i++) begin
            ones = ones + CNT_W'(word_i[i]);
        end
    end

    // ones minus zeros = 2*ones - DATA_W (modular intermediate, exact result)
    assign disp_o     = $signed(RD_W'(ones) << 1) - $signed(RD_W'(DATA_W));
    assign disp_pos_o = (disp_o > 0);

endmodule

// File: rtl/dcb_rd_accum.sv
module dcb_rd_accum #(
    parameter int DATA_W = 24,
    parameter int RD_W   = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bal_en,
    input  logic                   in_valid,
    input  logic                   invert,
    input  logic signed [RD_W-1:0] word_disp,
    output logic signed [RD_W-1:0] rd_q,
    output logic                   nxt_neg,
    output logic                   nxt_zero
);
    localparam logic signed [RD_W-1:0] ONE = RD_W'(1);

    logic signed [RD_W-1:0] sym_disp;
    logic signed [RD_W-1:0] rd_next;

    // Symbol = {flag, word}: inverted word negates disparity, flag adds +1 or -1
    always_comb begin
        if (invert) begin
            sym_disp = ONE - word_disp;
        end else begin
            sym_disp = word_disp - ONE;
        end
        rd_next  = rd_q + sym_disp;
        nxt_neg  = (rd_next < 0);
        nxt_zero = (rd_next == 0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (!bal_en) begin
            rd_q <= '0;
        end else if (in_valid) begin
            rd_q <= rd_next;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_q >= -DATA_W) && (rd_q <= DATA_W + 1)); // R9

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bal_en && !in_valid) |=> (rd_q == $past(rd_q))); // R10

    AST_OFF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !bal_en |=> (rd_q == 0)); // R11

endmodule

// File: rtl/dcb_polarity_fsm.sv
module dcb_polarity_fsm
    import dcb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bal_en,
    input  logic       in_valid,
    input  logic       word_pos,
    input  logic       nxt_neg,
    input  logic       nxt_zero,
    output logic       invert,
    output dcb_state_e state_q
);
    dcb_state_e state_d;
    dcb_state_e sign_state;

    always_comb begin
        if (nxt_zero) begin
            sign_state = ST_ZERO;
        end else if (nxt_neg) begin
            sign_state = ST_NEG;
        end else begin
            sign_state = ST_POS;
        end
    end

    // Transition logic
    always_comb begin
        state_d = state_q;
        if (!bal_en) begin
            state_d = ST_OFF;                      // T_DISABLE
        end else if (in_valid) begin
            state_d = sign_state;                  // T_TO_NEG / T_TO_ZERO / T_TO_POS
        end else begin
            unique case (state_q)
                ST_OFF:  state_d = ST_ZERO;        // T_ENABLE
                ST_ZERO: state_d = ST_ZERO;        // T_HOLD
                ST_NEG:  state_d = ST_NEG;         // T_HOLD
                ST_POS:  state_d = ST_POS;         // T_HOLD
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Output decision
    always_comb begin
        invert = 1'b0;
        unique case (state_q)
            ST_OFF:  invert = 1'b1;        // total is cleared while off: acts as zero
            ST_ZERO: invert = 1'b1;
            ST_NEG:  invert = !word_pos;
            ST_POS:  invert = word_pos;
        endcase
        invert = invert && bal_en && in_valid;
    end

    AST_ONLY_WHEN_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        invert |-> bal_en); // R2

endmodule

// File: rtl/dcb_word_encoder.sv
module dcb_word_encoder
    import dcb_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                bal_en,
    input  logic                                in_valid,
    input  logic [DATA_W-1:0]                   in_word,
    output logic                                out_valid,
    output logic [DATA_W-1:0]                   out_word,
    output logic                                out_flag,
    output logic signed [$clog2(DATA_W+2):0]    out_rd
);
    localparam int RD_W = $clog2(DATA_W + 2) + 1;

    logic signed [RD_W-1:0] word_disp;
    logic                   word_pos;
    logic                   invert;
    logic                   nxt_neg;
    logic                   nxt_zero;
    logic signed [RD_W-1:0] rd_q;
    dcb_state_e             state_q;

    dcb_word_disparity #(.DATA_W(DATA_W), .RD_W(RD_W)) disp_i (
        .word_i     (in_word),
        .disp_o     (word_disp),
        .disp_pos_o (word_pos)
    );

    dcb_polarity_fsm fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bal_en   (bal_en),
        .in_valid (in_valid),
        .word_pos (word_pos),
        .nxt_neg  (nxt_neg),
        .nxt_zero (nxt_zero),
        .invert   (invert),
        .state_q  (state_q)
    );

    dcb_rd_accum #(.DATA_W(DATA_W), .RD_W(RD_W)) acc_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bal_en    (bal_en),
        .in_valid  (in_valid),
        .invert    (invert),
        .word_disp (word_disp),
        .rd_q      (rd_q),
        .nxt_neg   (nxt_neg),
        .nxt_zero  (nxt_zero)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_word  <= '0;
            out_flag  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            out_flag  <= in_valid && invert;
            if (in_valid) begin
                out_word <= invert ? ~in_word : in_word;
            end
        end
    end

    assign out_rd = rd_q;

    AST_STATE_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_ZERO) -> (rd_q == 0)) &&
        ((state_q == ST_NEG)  -> (rd_q < 0))  &&
        ((state_q == ST_POS)  -> (rd_q > 0))); // R3

    AST_NEG_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        (bal_en && in_valid && (rd_q < 0)) |=> (rd_q > $past(rd_q))); // R5

    AST_POS_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (bal_en && in_valid && (rd_q > 0)) |=> (rd_q < $past(rd_q))); // R7

    AST_FLAG_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_flag); // R10

    AST_FLAG_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !bal_en |=> !out_flag); // R2

endmodule

// File: tb/dcb_word_encoder_tb.sv
module dcb_word_encoder_tb_top;
    localparam int W    = 24;
    localparam int RD_W = $clog2(W + 2) + 1;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   bal_en = 1'b0;
    logic                   in_valid = 1'b0;
    logic [W-1:0]           in_word = '0;
    logic                   out_valid;
    logic [W-1:0]           out_word;
    logic                   out_flag;
    logic signed [RD_W-1:0] out_rd;

    int checks = 0;
    int errors = 0;

    // Model state
    int          m_rd = 0;
    bit          have_exp = 0;
    bit          exp_valid = 0;
    bit          exp_flag = 0;
    logic [W-1:0] exp_word = '0;
    int          exp_rd = 0;
    string       exp_tag = "R1";

    always #2 clk = ~clk;

    dcb_word_encoder #(.DATA_W(W)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bal_en    (bal_en),
        .in_valid  (in_valid),
        .in_word   (in_word),
        .out_valid (out_valid),
        .out_word  (out_word),
        .out_flag  (out_flag),
        .out_rd    (out_rd)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int ones_of(input logic [W-1:0] w);
        int n = 0;
        for (int i = 0; i < W; i++) n += int'(w[i]);
        return n;
    endfunction

    task automatic step(input bit b, input bit v, input logic [W-1:0] w);
        int wd;
        bit inv;
        @(negedge clk);
        if (have_exp) begin
            chk("R10 out_valid", int'(out_valid), int'(exp_valid));
            if (exp_valid) chk({exp_tag, " out_word"}, int'(out_word), int'(exp_word));
            chk({exp_tag, " out_flag"}, int'(out_flag), int'(exp_flag));
            chk("R8/R11 out_rd", int'(out_rd), exp_rd);
            chk("R9 range", int'((int'(out_rd) >= -W) && (int'(out_rd) <= W + 1)), 1);
        end
        bal_en = b; in_valid = v; in_word = w;
        wd = 2 * ones_of(w) - W;
        if (!b)             begin inv = 0; exp_tag = "R2"; end
        else if (m_rd == 0) begin inv = 1; exp_tag = "R3"; end
        else if (m_rd < 0)  begin
            if (wd > 0) begin inv = 0; exp_tag = "R4"; end
            else        begin inv = 1; exp_tag = "R5"; end
        end else begin
            if (wd > 0) begin inv = 1; exp_tag = "R7"; end
            else        begin inv = 0; exp_tag = "R6"; end
        end
        if (!v) exp_tag = "R10";
        exp_valid = v;
        exp_flag  = v && inv;
        if (v) exp_word = inv ? ~w : w;
        if (!b) m_rd = 0;
        else if (v) m_rd += 2 * (ones_of(inv ? ~w : w) + int'(inv)) - (W + 1);
        exp_rd = m_rd;
        have_exp = 1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog all-requirements actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [W-1:0] bal_word;
        bal_word = {{(W/2){1'b0}}, {(W/2){1'b1}}};   // disparity 0
        repeat (3) @(negedge clk);
        chk("R1 reset out_valid", int'(out_valid), 0);
        chk("R1 reset out_flag", int'(out_flag), 0);
        chk("R1 reset out_rd", int'(out_rd), 0);
        @(negedge clk);
        rst_n = 1'b1;
        have_exp = 1; exp_valid = 0; exp_flag = 0; exp_rd = 0; exp_tag = "R1";

        // R2: pass-through with balancing off
        for (int i = 0; i < 20; i++) step(0, 1, W'($urandom));
        step(0, 1, '1);
        step(0, 0, '0);

        // Directed walk through every rule and both range ends
        step(1, 0, '0);          // enable, no word
        step(1, 1, '1);          // R3: zero -> invert, rd = -23
        step(1, 0, '0);          // R10 hold
        step(1, 1, bal_word);    // R5: neg, balanced word -> invert, rd = -22
        step(1, 1, '1);          // R4: neg, positive word -> pass, rd = +1
        step(1, 1, '0);          // R6: pos, negative word -> pass, rd = -24 (R9 low end)
        step(1, 1, '0);          // R5: neg, negative -> invert, rd = +1
        step(1, 1, bal_word);    // R6: pos, balanced -> pass, rd = 0
        step(1, 1, '0);          // R3: zero -> invert, rd = +25 (R9 high end)
        step(1, 1, '1);          // R7: pos, positive -> invert, rd = +2
        step(1, 0, '0);
        step(0, 1, '1);          // R11 clear
        step(1, 1, '0);          // R11 restart from zero: invert
        step(1, 1, W'($urandom));

        // Random run with gaps and enable drops
        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 16) != 0, ($urandom % 4) != 0,
                 (($urandom % 5) == 0) ? (($urandom % 2) ? '1 : '0) : W'($urandom));
        end
        step(1, 0, '0);
        step(1, 0, '0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule